// File: doc/BRIEF.md
# Per-Fault Differential State Store

This block replaces the state flip-flops of a sequential circuit that is being fault-graded one faulty machine at a time against a single test vector. It keeps one fault-free copy of the state. For each faulty machine it keeps only those flip-flops whose value differs from that copy, in a small associative table keyed by fault id.

The driver first runs the fault-free machine and saves its next state. It then selects each faulty machine in turn. A restore loads that machine's present state onto the outputs: the stored value for every flip-flop that has a difference entry, and the fault-free value for every other flip-flop. After the faulty run, a save records the new differences. If none remain, the entry is removed. A drop command frees a detected fault's entry. A clear returns everything to the unknown state.

Each flip-flop carries a value bit and a known bit. An unknown bit always reads with value 0. Two unknown bits count as equal. An unknown bit and a known bit count as different.

Top module: `dss_top`

## Requirements
- R1: After reset or a clear, every present-state bit reads unknown (psKnown 0, psVal 0), overflow is 0, and no table entry exists.
- R2: A save with faultActive=0 captures nextVal/nextKnown as the fault-free state. A later restore for a fault that has no entry presents exactly that state.
- R3: A save with faultActive=1 records, under faultId, the flip-flops whose next state differs from the fault-free state. A restore of that fault presents the stored value on exactly those bits.
- R4: Bits that were equal to the fault-free state when a faulty machine was saved follow later fault-free saves when that fault is restored.
- R5: A faulty save whose next state equals the fault-free state removes that fault's entry, and the freed slot becomes reusable.
- R6: dropCmd removes the entry of faultId, so a later restore of that fault presents the fault-free state.
- R7: A faulty save that needs a new entry while all DEPTH entries are in use stores nothing and sets overflow. overflow stays set until a clear.
- R8: A restore with faultActive=0 presents the fault-free state even if an entry exists for faultId.
- R9: psVal/psKnown change only on a restore or a clear, and psVal is 0 wherever psKnown is 0.
- R10: When several commands are asserted in one cycle, only one acts, in this priority order: clearCmd, then saveCmd, then dropCmd, then restoreCmd.
- R11: An unknown next-state bit where the fault-free bit is known counts as a difference and is stored as unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clearCmd | input | 1 | Mark all state unknown and empty the table |
| saveCmd | input | 1 | Record the next state (fault-free or the selected fault) |
| restoreCmd | input | 1 | Load the present-state outputs for the selected machine |
| dropCmd | input | 1 | Free the entry of faultId |
| faultActive | input | 1 | 1 selects a faulty machine, 0 selects the fault-free machine |
| faultId | input | FAULT_W | Id of the selected faulty machine |
| nextVal | input | NUM_FF | Next-state values from the circuit |
| nextKnown | input | NUM_FF | Known bits of the next state |
| psVal | output | NUM_FF | Present-state values |
| psKnown | output | NUM_FF | Present-state known bits |
| overflow | output | 1 | Sticky flag: a difference could not be stored |

## Verification
The bench builds the block with NUM_FF=8, DEPTH=4 and FAULT_W=4. It draws fault ids from 0 to 7, so the four-entry table fills often. This makes it possible to reach overflow, slot reuse after a deletion, and a replacement entry landing in a freed slot within a few hundred operations. Eight flip-flops are enough to mix known and unknown bits and to cover both partial and total differences in each save.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef struct packed {
    logic clearAll;
    logic goodWr;
    logic entWr;
    logic entKill;
    logic ovfSet;
    logic psLoad;
    logic psUseEnt;
  } dssStrobe_t;
endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clearCmd,
  input  logic             saveCmd,
  input  logic             restoreCmd,
  input  logic             dropCmd,
  input  logic             faultActive,
  input  logic [DEPTH-1:0] hitVec,
  input  logic [DEPTH-1:0] freeVec,
  input  logic             diffNz,
  output dssStrobe_t       stb,
  output logic [IDX_W-1:0] slot
);
  logic             hitAny;
  logic             freeAny;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;

  // lowest-index encoders for the matching entry and the first free entry
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i])  hitIdx  = IDX_W'(i);
      if (freeVec[i]) freeIdx = IDX_W'(i);
    end
    hitAny  = |hitVec;
    freeAny = |freeVec;
  end

  // one command acts per cycle: clear > save > drop > restore
  always_comb begin
    stb  = '0;
    slot = hitIdx;
    if (clearCmd) begin
      stb.clearAll = 1'b1;
    end else if (saveCmd) begin
      if (!faultActive) begin
        stb.goodWr = 1'b1;
      end else if (hitAny) begin
        if (diffNz) stb.entWr   = 1'b1;
        else        stb.entKill = 1'b1;
      end else if (diffNz) begin
        if (freeAny) begin
          stb.entWr = 1'b1;
          slot      = freeIdx;
        end else begin
          stb.ovfSet = 1'b1;
        end
      end
    end else if (dropCmd) begin
      if (hitAny) stb.entKill = 1'b1;
    end else if (restoreCmd) begin
      stb.psLoad   = 1'b1;
      stb.psUseEnt = faultActive & hitAny;
    end
  end
endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int NUM_FF  = 16,
  parameter int DEPTH   = 8,
  parameter int FAULT_W = 10,
  parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dssStrobe_t         stb,
  input  logic [IDX_W-1:0]   slot,
  input  logic [FAULT_W-1:0] faultId,
  input  logic [NUM_FF-1:0]  nextVal,
  input  logic [NUM_FF-1:0]  nextKnown,
  output logic [DEPTH-1:0]   hitVec,
  output logic [DEPTH-1:0]   freeVec,
  output logic               diffNz,
  output logic [NUM_FF-1:0]  psVal,
  output logic [NUM_FF-1:0]  psKnown,
  output logic               overflow
);
  logic [NUM_FF-1:0]  goodVal;
  logic [NUM_FF-1:0]  goodKnown;
  logic [DEPTH-1:0]   entValid;
  logic [FAULT_W-1:0] entId    [DEPTH];
  logic [NUM_FF-1:0]  entMask  [DEPTH];
  logic [NUM_FF-1:0]  entVal   [DEPTH];
  logic [NUM_FF-1:0]  entKnown [DEPTH];

  logic [NUM_FF-1:0]  nextValC;
  logic [NUM_FF-1:0]  diffMask;
  logic [NUM_FF-1:0]  selMask;
  logic [NUM_FF-1:0]  selVal;
  logic [NUM_FF-1:0]  selKnown;

  // associative match and free flags, one per entry
  for (genvar g = 0; g < DEPTH; g++) begin : gCam
    assign hitVec[g]  = entValid[g] && (entId[g] == faultId);
    assign freeVec[g] = ~entValid[g];
  end

  // difference against the fault-free state, unknown bits carried as value 0
  always_comb begin
    nextValC = nextVal & nextKnown;
    diffMask = (nextKnown ^ goodKnown) | (nextKnown & goodKnown & (nextValC ^ goodVal));
    diffNz   = |diffMask;
    selMask  = entMask[slot];
    selVal   = entVal[slot];
    selKnown = entKnown[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goodVal   <= '0;
      goodKnown <= '0;
    end else if (stb.clearAll) begin
      goodVal   <= '0;
      goodKnown <= '0;
    end else if (stb.goodWr) begin
      goodVal   <= nextValC;
      goodKnown <= nextKnown;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.clearAll)                             entValid[i] <= 1'b0;
        else if (stb.entWr && (slot == IDX_W'(i)))   entValid[i] <= 1'b1;
        else if (stb.entKill && (slot == IDX_W'(i))) entValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!stb.clearAll && stb.entWr && (slot == IDX_W'(i))) begin
        entId[i]    <= faultId;
        entMask[i]  <= diffMask;
        entVal[i]   <= nextValC & diffMask;
        entKnown[i] <= nextKnown & diffMask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psVal   <= '0;
      psKnown <= '0;
    end else if (stb.clearAll) begin
      psVal   <= '0;
      psKnown <= '0;
    end else if (stb.psLoad) begin
      if (stb.psUseEnt) begin
        psVal   <= (selMask & selVal)   | (~selMask & goodVal);
        psKnown <= (selMask & selKnown) | (~selMask & goodKnown);
      end else begin
        psVal   <= goodVal;
        psKnown <= goodKnown;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            overflow <= 1'b0;
    else if (stb.clearAll) overflow <= 1'b0;
    else if (stb.ovfSet)   overflow <= 1'b1;
  end
endmodule

// File: rtl/dss_top.sv
module dss_top
  import dss_pkg::*;
#(
  parameter int NUM_FF  = 16,
  parameter int DEPTH   = 8,
  parameter int FAULT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clearCmd,
  input  logic               saveCmd,
  input  logic               restoreCmd,
  input  logic               dropCmd,
  input  logic               faultActive,
  input  logic [FAULT_W-1:0] faultId,
  input  logic [NUM_FF-1:0]  nextVal,
  input  logic [NUM_FF-1:0]  nextKnown,
  output logic [NUM_FF-1:0]  psVal,
  output logic [NUM_FF-1:0]  psKnown,
  output logic               overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dssStrobe_t       stb;
  logic [IDX_W-1:0] slot;
  logic [DEPTH-1:0] hitVec;
  logic [DEPTH-1:0] freeVec;
  logic             diffNz;

  dss_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ctrl (
    .clearCmd(clearCmd), .saveCmd(saveCmd), .restoreCmd(restoreCmd),
    .dropCmd(dropCmd), .faultActive(faultActive), .hitVec(hitVec),
    .freeVec(freeVec), .diffNz(diffNz), .stb(stb), .slot(slot)
  );

  dss_datapath #(.NUM_FF(NUM_FF), .DEPTH(DEPTH), .FAULT_W(FAULT_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .slot(slot), .faultId(faultId),
    .nextVal(nextVal), .nextKnown(nextKnown), .hitVec(hitVec), .freeVec(freeVec),
    .diffNz(diffNz), .psVal(psVal), .psKnown(psKnown), .overflow(overflow)
  );
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int NUM_FF = 16,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clearCmd,
  input logic              restoreCmd,
  input logic [NUM_FF-1:0] psVal,
  input logic [NUM_FF-1:0] psKnown,
  input logic              overflow,
  input logic [DEPTH-1:0]  hitVec
);
  AST_ID_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hitVec)); // R3
  AST_PS_CANON: assert property (@(posedge clk) disable iff (!rst_n) (psVal & ~psKnown) == '0); // R9
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restoreCmd && !clearCmd) |=> ($stable(psVal) && $stable(psKnown))); // R9
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clearCmd |=> (psKnown == '0 && !overflow && hitVec == '0)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clearCmd) |=> overflow); // R7
endmodule

bind dss_top dss_checker #(.NUM_FF(NUM_FF), .DEPTH(DEPTH)) i_dssChk (
  .clk(clk), .rst_n(rst_n), .clearCmd(clearCmd), .restoreCmd(restoreCmd),
  .psVal(psVal), .psKnown(psKnown), .overflow(overflow), .hitVec(hitVec)
);

// File: tb/test_dss_top.sv
module test_dss_top;
  localparam int CLK_PERIOD = 10;
  localparam int NFF = 8;
  localparam int DEP = 4;
  localparam int FW  = 4;
  localparam int NID = 1 << FW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clearCmd = 1'b0, saveCmd = 1'b0, restoreCmd = 1'b0, dropCmd = 1'b0, faultActive = 1'b0;
  logic [FW-1:0]  faultId = '0;
  logic [NFF-1:0] nextVal = '0, nextKnown = '0;
  logic [NFF-1:0] psVal, psKnown;
  logic           overflow;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference state kept by the bench
  logic [NFF-1:0] mGoodVal = '0, mGoodKnown = '0, mPsVal = '0, mPsKnown = '0;
  logic           mOvf = 1'b0;
  logic           mHas   [NID];
  logic [NFF-1:0] mMask  [NID];
  logic [NFF-1:0] mVal   [NID];
  logic [NFF-1:0] mKnown [NID];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dss_top #(.NUM_FF(NFF), .DEPTH(DEP), .FAULT_W(FW)) i_dss_top (
    .clk(clk), .rst_n(rst_n), .clearCmd(clearCmd), .saveCmd(saveCmd),
    .restoreCmd(restoreCmd), .dropCmd(dropCmd), .faultActive(faultActive),
    .faultId(faultId), .nextVal(nextVal), .nextKnown(nextKnown),
    .psVal(psVal), .psKnown(psKnown), .overflow(overflow)
  );

  function automatic int usedCount();
    int n = 0;
    for (int i = 0; i < NID; i++) if (mHas[i]) n++;
    return n;
  endfunction

  function automatic logic [NFF-1:0] diffOf(logic [NFF-1:0] v, logic [NFF-1:0] k);
    logic [NFF-1:0] d;
    for (int b = 0; b < NFF; b++)
      d[b] = (k[b] != mGoodKnown[b]) || (k[b] && mGoodKnown[b] && (v[b] != mGoodVal[b]));
    return d;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < NID; i++) mHas[i] = 1'b0;
    mGoodVal = '0; mGoodKnown = '0; mPsVal = '0; mPsKnown = '0; mOvf = 1'b0;
  endtask

  task automatic modelStep(logic cl, logic sv, logic rs, logic dr, logic fa,
                           logic [FW-1:0] id, logic [NFF-1:0] v, logic [NFF-1:0] k);
    logic [NFF-1:0] d;
    if (cl) modelClear();
    else if (sv) begin
      if (!fa) begin
        mGoodVal = v & k; mGoodKnown = k;
      end else begin
        d = diffOf(v, k);
        if (d == '0) mHas[id] = 1'b0;
        else if (mHas[id] || usedCount() < DEP) begin
          mHas[id] = 1'b1; mMask[id] = d; mVal[id] = v & k & d; mKnown[id] = k & d;
        end else mOvf = 1'b1;
      end
    end else if (dr) mHas[id] = 1'b0;
    else if (rs) begin
      if (fa && mHas[id]) begin
        mPsVal   = (mMask[id] & mVal[id])   | (~mMask[id] & mGoodVal);
        mPsKnown = (mMask[id] & mKnown[id]) | (~mMask[id] & mGoodKnown);
      end else begin
        mPsVal = mGoodVal; mPsKnown = mGoodKnown;
      end
    end
  endtask

  // called at a falling edge; applies one cycle of commands
  task automatic drive(logic cl, logic sv, logic rs, logic dr, logic fa,
                       logic [FW-1:0] id, logic [NFF-1:0] v, logic [NFF-1:0] k);
    clearCmd = cl; saveCmd = sv; restoreCmd = rs; dropCmd = dr;
    faultActive = fa; faultId = id; nextVal = v; nextKnown = k;
    @(posedge clk);
    modelStep(cl, sv, rs, dr, fa, id, v, k);
    @(negedge clk);
    clearCmd = 1'b0; saveCmd = 1'b0; restoreCmd = 1'b0; dropCmd = 1'b0;
  endtask

  task automatic saveG(logic [NFF-1:0] v, logic [NFF-1:0] k);
    drive(0, 1, 0, 0, 0, '0, v, k);
  endtask
  task automatic saveF(logic [FW-1:0] id, logic [NFF-1:0] v, logic [NFF-1:0] k);
    drive(0, 1, 0, 0, 1, id, v, k);
  endtask
  task automatic rest(logic fa, logic [FW-1:0] id);
    drive(0, 0, 1, 0, fa, id, '0, '0);
  endtask

  task automatic chk(string req, logic [NFF-1:0] ev, logic [NFF-1:0] ek, logic eo);
    tests++;
    if (psVal !== ev || psKnown !== ek || overflow !== eo) begin
      fails++;
      $display("FAIL %s: got val=%h known=%h ovf=%b, expected val=%h known=%h ovf=%b",
               req, psVal, psKnown, overflow, ev, ek, eo);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    logic [NFF-1:0] v, k;
    logic [FW-1:0]  id;
    int             r;
    modelClear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 8'h00, 8'h00, 0);

    saveG(8'hA5, 8'hFF);
    rest(0, 0);              chk("R2 good restore", 8'hA5, 8'hFF, 0);
    rest(1, 3);              chk("R2 no entry", 8'hA5, 8'hFF, 0);
    saveF(3, 8'hA4, 8'hFF);
    rest(1, 3);              chk("R3 faulty restore", 8'hA4, 8'hFF, 0);
    saveG(8'hA7, 8'hFF);
    rest(1, 3);              chk("R4 undiffered bits follow good", 8'hA6, 8'hFF, 0);
    saveF(5, 8'hA7, 8'h7F);
    rest(1, 5);              chk("R11 unknown stored", 8'h27, 8'h7F, 0);
    tests++;
    if ((psVal & ~psKnown) != '0) begin
      fails++; $display("FAIL R9: got val=%h known=%h, expected val 0 where unknown", psVal, psKnown);
    end
    saveF(6, 8'hA7, 8'hFF);
    saveF(3, 8'hA7, 8'hFF);
    rest(1, 3);              chk("R5 equal save deletes", 8'hA7, 8'hFF, 0);
    drive(0, 0, 0, 1, 0, 5, '0, '0);
    rest(1, 5);              chk("R6 drop", 8'hA7, 8'hFF, 0);
    saveF(2, 8'h00, 8'hFF);
    rest(0, 2);              chk("R8 fault-free selection", 8'hA7, 8'hFF, 0);
    rest(1, 2);              chk("R3 entry present", 8'h00, 8'hFF, 0);
    saveF(8, 8'h01, 8'hFF);
    saveF(9, 8'h02, 8'hFF);
    saveF(10, 8'h03, 8'hFF);
    rest(1, 10);             chk("R7 full without overflow", 8'h03, 8'hFF, 0);
    saveF(11, 8'hF0, 8'hFF);
    rest(1, 11);             chk("R7 overflow, not stored", 8'hA7, 8'hFF, 1);
    saveF(8, 8'hA7, 8'hFF);
    saveF(11, 8'hF0, 8'hFF);
    rest(1, 11);             chk("R5 freed slot reused, R7 sticky", 8'hF0, 8'hFF, 1);
    drive(1, 1, 1, 0, 1, 11, 8'h0F, 8'hFF);
    rest(1, 11);             chk("R10 clear wins, R1 cleared", 8'h00, 8'h00, 0);
    saveG(8'h3C, 8'hFF);
    drive(0, 1, 0, 1, 1, 4, 8'h3D, 8'hFF);
    rest(1, 4);              chk("R10 save over drop", 8'h3D, 8'hFF, 0);
    drive(0, 1, 1, 0, 0, 0, 8'h55, 8'hFF);
    chk("R10 save over restore, R9 hold", 8'h3D, 8'hFF, 0);
    rest(0, 0);              chk("R2 good updated", 8'h55, 8'hFF, 0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 500; n++) begin
      r  = int'($urandom % 32);
      id = FW'($urandom % 8);
      if ($urandom % 3 == 0) begin
        v = mGoodVal; k = mGoodKnown;
      end else begin
        k = ($urandom % 4 == 0) ? NFF'($urandom) : '1;
        v = mGoodVal ^ (($urandom % 2 == 0) ? NFF'($urandom) : NFF'(1 << ($urandom % NFF)));
      end
      if (r == 0)       drive(1, 0, 0, 0, 0, id, v, k);
      else if (r < 9)   drive(0, 1, 0, 0, ($urandom % 4 != 0), id, v, k);
      else if (r < 12)  drive(0, 0, 0, 1, 0, id, v, k);
      else              drive(0, 0, 1, 0, ($urandom % 5 != 0), id, v, k);
      chk("R3/R9 random", mPsVal, mPsKnown, mOvf);
    end
    finishRun();
  end
endmodule